// File: doc/BRIEF.md
# UART Interrupt Identification and Priority

This block turns the pending interrupt conditions of a 16550-style serial port into an identification value and one interrupt line. It holds the four-bit interrupt enable register. It also holds a sticky flag that marks the transmit holding register as empty. Each cycle it combines the enables with the status inputs: the line error bits, data ready, receive FIFO count against the trigger level, the character-timeout flag, the pending flag and the modem delta bits. From these it registers the code of the single highest-priority enabled source.

The enclosing port logic feeds the block with strobes. These mark an enable-register write, a read of the identification register, and the moment the transmit holding register or FIFO drains. A read of the identification value while it reports the holding-empty code acknowledges that source. Raising the holding-empty enable while the holding register is already empty re-arms it. The two upper identification bits report whether the FIFOs are enabled.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset `iir` is 0x01, `ier_q` is 0 and `irq` is 0, and no holding-empty source is pending.
- R2: Line status (code 0x6 in `iir[3:0]`) is reported when `ier_q[2]` is 1 and any bit of `lsr_err` is 1. It outranks every other source.
- R3: Character timeout (code 0xC) is reported when `ier_q[0]` is 1 and `char_timeout` is 1, unless R2 applies. With `ier_q[0]` at 0 the timeout is never reported.
- R4: Receive data (code 0x4) is reported when `ier_q[0]` and `lsr_dr` are 1, and either `fifo_en` is 0 or `rx_count >= rx_trig`, unless R2 or R3 applies.
- R5: Holding empty (code 0x2) is reported when `ier_q[1]` is 1 and the holding-empty flag is pending, unless R2 to R4 apply.
- R6: Modem status (code 0x0) is reported when `ier_q[3]` is 1 and any bit of `msr_delta` is 1, unless R2 to R5 apply. With no source reported the low nibble is 0x1.
- R7: `iir[7:6]` is 2'b11 while `fifo_en` is 1 and 2'b00 otherwise. `iir[5:4]` is always 0.
- R8: `iir` and `irq` are registered one clock after their inputs. `irq` is 1 exactly when `iir[3:0]` is not 0x1.
- R9: A pulse on `thr_empty_evt` sets the holding-empty flag.
- R10: An `iir_rd_en` pulse clears the flag while `iir[3:0]` shows 0x2. A read while another code shows leaves the flag unchanged.
- R11: An enable write takes bit 1 from 0 to 1. If `lsr_thre` is 1 at that write, it sets the flag. Otherwise, or if bit 1 was already 1, the flag is left as it was.
- R12: An enable write with bit 1 at 0 forces the flag to 0.
- R13: `ier_q` holds the last value written through `ier_wr_en`/`ier_wr_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ier_wr_en | input | 1 | Enable register write strobe |
| ier_wr_data | input | 4 | Enable bits: 0 receive, 1 holding empty, 2 line status, 3 modem |
| ier_q | output | 4 | Current enable register |
| iir_rd_en | input | 1 | Identification register read strobe |
| thr_empty_evt | input | 1 | Pulse: transmit holding register or FIFO became empty |
| lsr_thre | input | 1 | Holding register currently empty |
| lsr_err | input | 4 | Overrun, parity, framing, break status bits |
| lsr_dr | input | 1 | Receive data ready |
| fifo_en | input | 1 | FIFOs enabled |
| rx_count | input | CNT_W | Receive FIFO occupancy |
| rx_trig | input | CNT_W | Receive trigger level |
| char_timeout | input | 1 | Character timeout pending |
| msr_delta | input | 4 | Modem status delta bits |
| iir | output | 8 | Identification value |
| irq | output | 1 | Active-high interrupt |

## Verification
A sweep runs every enable value against every presence pattern of the five sources. The patterns vary which error bit and which delta bit is set. For each pattern it also sets the FIFO mode and puts the receive count on either side of the trigger level. This separates a broken priority order, a missing enable mask, and an off-by-one trigger compare, including timeout masking by the receive enable. Directed sequences then test the pending flag. They cover a set by the empty pulse and a read that acknowledges it. They cover a read that is ignored because a higher source is showing. They cover re-arming on an enable rise with and without the holding register empty, a rewrite that keeps bit 1 set, and clearing by an enable write.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam logic [3:0] CODE_NONE = 4'h1;
  localparam logic [3:0] CODE_LINE = 4'h6;
  localparam logic [3:0] CODE_TMO  = 4'hC;
  localparam logic [3:0] CODE_RXD  = 4'h4;
  localparam logic [3:0] CODE_THRE = 4'h2;
  localparam logic [3:0] CODE_MDM  = 4'h0;

  typedef struct packed {
    logic line;
    logic tmo;
    logic rxd;
    logic thre;
    logic mdm;
  } irq_src_t;

  // Highest enabled source wins; order is line, timeout, data, empty, modem.
  function automatic logic [3:0] pick_code(irq_src_t s);
    if (s.line)      return CODE_LINE;
    else if (s.tmo)  return CODE_TMO;
    else if (s.rxd)  return CODE_RXD;
    else if (s.thre) return CODE_THRE;
    else if (s.mdm)  return CODE_MDM;
    else             return CODE_NONE;
  endfunction

  function automatic logic [1:0] fifo_flags(logic en);
    return en ? 2'b11 : 2'b00;
  endfunction
endpackage

// File: rtl/uart_irq_ier_reg.sv
module uart_irq_ier_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [3:0] wr_data,
  output logic [3:0] ier_q,
  output logic       thre_en_rise,
  output logic       thre_en_drop
);
  assign thre_en_rise = wr_en && wr_data[1] && !ier_q[1];
  assign thre_en_drop = wr_en && !wr_data[1];

  always_ff @(posedge clk) begin
    if (!rst_n)     ier_q <= 4'h0;
    else if (wr_en) ier_q <= wr_data;
  end
endmodule

// File: rtl/uart_irq_thre_track.sv
module uart_irq_thre_track (
  input  logic clk,
  input  logic rst_n,
  input  logic en_rise,
  input  logic en_drop,
  input  logic lsr_thre,
  input  logic empty_evt,
  input  logic read_hit,
  output logic pend
);
  logic pend_d;

  always_comb begin
    pend_d = pend;
    if (en_drop)                    pend_d = 1'b0;
    else if (en_rise && lsr_thre)   pend_d = 1'b1;
    else if (empty_evt)             pend_d = 1'b1;
    else if (read_hit)              pend_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pend <= 1'b0;
    else        pend <= pend_d;
  end
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic [3:0]       ier,
  input  logic [3:0]       lsr_err,
  input  logic             lsr_dr,
  input  logic             fifo_en,
  input  logic [CNT_W-1:0] rx_count,
  input  logic [CNT_W-1:0] rx_trig,
  input  logic             char_timeout,
  input  logic             thre_pend,
  input  logic [3:0]       msr_delta,
  output logic [3:0]       code
);
  irq_src_t src;
  logic     level_ok;

  assign level_ok = !fifo_en || (rx_count >= rx_trig);

  always_comb begin
    src.line = ier[2] && (|lsr_err);
    src.tmo  = ier[0] && char_timeout;
    src.rxd  = ier[0] && lsr_dr && level_ok;
    src.thre = ier[1] && thre_pend;
    src.mdm  = ier[3] && (|msr_delta);
    code     = pick_code(src);
  end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ier_wr_en,
  input  logic [3:0]       ier_wr_data,
  output logic [3:0]       ier_q,
  input  logic             iir_rd_en,
  input  logic             thr_empty_evt,
  input  logic             lsr_thre,
  input  logic [3:0]       lsr_err,
  input  logic             lsr_dr,
  input  logic             fifo_en,
  input  logic [CNT_W-1:0] rx_count,
  input  logic [CNT_W-1:0] rx_trig,
  input  logic             char_timeout,
  input  logic [3:0]       msr_delta,
  output logic [7:0]       iir,
  output logic             irq
);
  logic       thre_en_rise;
  logic       thre_en_drop;
  logic       thre_pend;
  logic       read_hit;
  logic [3:0] code_now;
  logic [7:0] iir_q;
  logic       irq_q;

  uart_irq_ier_reg u_ier (
    .clk(clk), .rst_n(rst_n), .wr_en(ier_wr_en), .wr_data(ier_wr_data),
    .ier_q(ier_q), .thre_en_rise(thre_en_rise), .thre_en_drop(thre_en_drop)
  );

  // Acknowledge only when the value being read reports the empty code.
  assign read_hit = iir_rd_en && (iir_q[3:0] == CODE_THRE);

  uart_irq_thre_track u_thre (
    .clk(clk), .rst_n(rst_n), .en_rise(thre_en_rise), .en_drop(thre_en_drop),
    .lsr_thre(lsr_thre), .empty_evt(thr_empty_evt), .read_hit(read_hit),
    .pend(thre_pend)
  );

  uart_irq_prio #(.CNT_W(CNT_W)) u_prio (
    .ier(ier_q), .lsr_err(lsr_err), .lsr_dr(lsr_dr), .fifo_en(fifo_en),
    .rx_count(rx_count), .rx_trig(rx_trig), .char_timeout(char_timeout),
    .thre_pend(thre_pend), .msr_delta(msr_delta), .code(code_now)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      iir_q <= {4'h0, CODE_NONE};
      irq_q <= 1'b0;
    end else begin
      iir_q <= {fifo_flags(fifo_en), 2'b00, code_now};
      irq_q <= (code_now != CODE_NONE);
    end
  end

  assign iir = iir_q;
  assign irq = irq_q;
endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] ier_q,
  input logic       ier_wr_en,
  input logic [3:0] ier_wr_data,
  input logic       iir_rd_en,
  input logic       thr_empty_evt,
  input logic [3:0] lsr_err,
  input logic       fifo_en,
  input logic [7:0] iir,
  input logic       irq,
  input logic       thre_pend
);
  assert_line_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ier_q[2] && (|lsr_err)) |=> (iir[3:0] == 4'h6));

  assert_tmo_masked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ier_q[0]) |=> (iir[3:0] != 4'hC));

  assert_fifo_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (iir[7:6] == {2{$past(fifo_en)}}) && (iir[5:4] == 2'b00));

  assert_irq_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (iir[3:0] != 4'h1));

  assert_empty_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_empty_evt && !(ier_wr_en && !ier_wr_data[1])) |=> thre_pend);

  assert_read_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (iir_rd_en && iir[3:0] == 4'h2 && !thr_empty_evt && !ier_wr_en) |=> !thre_pend);

  assert_drop_clears_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (ier_wr_en && !ier_wr_data[1]) |=> !thre_pend);
endmodule

bind uart_irq_ident uart_irq_ident_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ier_q(ier_q), .ier_wr_en(ier_wr_en),
  .ier_wr_data(ier_wr_data), .iir_rd_en(iir_rd_en), .thr_empty_evt(thr_empty_evt),
  .lsr_err(lsr_err), .fifo_en(fifo_en), .iir(iir), .irq(irq), .thre_pend(thre_pend)
);

// File: tb/test_uart_irq_ident.sv
module test_uart_irq_ident;
  localparam int CW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ier_wr_en = 1'b0;
  logic [3:0] ier_wr_data = 4'h0;
  logic [3:0] ier_q;
  logic iir_rd_en = 1'b0;
  logic thr_empty_evt = 1'b0;
  logic lsr_thre = 1'b0;
  logic [3:0] lsr_err = 4'h0;
  logic lsr_dr = 1'b0;
  logic fifo_en = 1'b0;
  logic [CW-1:0] rx_count = '0;
  logic [CW-1:0] rx_trig = '0;
  logic char_timeout = 1'b0;
  logic [3:0] msr_delta = 4'h0;
  logic [7:0] iir;
  logic irq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  uart_irq_ident i_uart_irq_ident (
    .clk(clk), .rst_n(rst_n), .ier_wr_en(ier_wr_en), .ier_wr_data(ier_wr_data),
    .ier_q(ier_q), .iir_rd_en(iir_rd_en), .thr_empty_evt(thr_empty_evt),
    .lsr_thre(lsr_thre), .lsr_err(lsr_err), .lsr_dr(lsr_dr), .fifo_en(fifo_en),
    .rx_count(rx_count), .rx_trig(rx_trig), .char_timeout(char_timeout),
    .msr_delta(msr_delta), .iir(iir), .irq(irq)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Expected identification value, restated from the requirements.
  function automatic int expect_iir(int ier, bit err, bit dr, bit tmo, bit fe,
                                    bit lvl, bit pend, bit mdm);
    int lo;
    int hi;
    hi = fe ? 8'hC0 : 8'h00;
    if (ier[2] && err)                   lo = 6;
    else if (ier[0] && tmo)              lo = 12;
    else if (ier[0] && dr && (!fe || lvl)) lo = 4;
    else if (ier[1] && pend)             lo = 2;
    else if (ier[3] && mdm)              lo = 0;
    else                                 lo = 1;
    return hi | lo;
  endfunction

  task automatic write_ier(input logic [3:0] v);
    @(negedge clk); ier_wr_en = 1'b1; ier_wr_data = v;
    @(negedge clk); ier_wr_en = 1'b0;
  endtask

  task automatic pulse_empty();
    @(negedge clk); thr_empty_evt = 1'b1;
    @(negedge clk); thr_empty_evt = 1'b0;
  endtask

  task automatic read_iir();
    @(negedge clk); iir_rd_en = 1'b1;
    @(negedge clk); iir_rd_en = 1'b0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic quiet();
    lsr_err = 4'h0; lsr_dr = 1'b0; char_timeout = 1'b0; msr_delta = 4'h0;
    lsr_thre = 1'b0; fifo_en = 1'b0; rx_count = '0; rx_trig = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 iir", iir, 8'h01);
    check("R1 ier", ier_q, 0);
    check("R1 irq", irq, 0);
    write_ier(4'h2); settle();
    check("R1 no pending empty after reset", iir, 8'h01);

    // Sweep: R2 R3 R4 R5 R6 R7 R8 R13
    for (int idx = 0; idx < 2048; idx++) begin
      logic [3:0] ier_v;
      bit err, dr, tmo, fe, lvl, mdm, pend;
      int trig;
      int exp;
      ier_v = idx[3:0];
      err = idx[4]; dr = idx[5]; tmo = idx[6]; fe = idx[7];
      lvl = idx[8]; mdm = idx[9]; pend = idx[10];
      quiet();
      write_ier(4'h0);
      write_ier(ier_v);
      if (pend) pulse_empty();
      trig = 4 + 3 * int'(idx[1:0]);
      lsr_err = err ? (4'h1 << idx[6:5]) : 4'h0;
      lsr_dr = dr; char_timeout = tmo; fifo_en = fe;
      msr_delta = mdm ? (4'h1 << idx[5:4]) : 4'h0;
      rx_trig = CW'(trig);
      rx_count = lvl ? CW'(trig + int'(idx[4])) : CW'(trig - 1);
      settle();
      exp = expect_iir(int'(ier_v), err, dr, tmo, fe, lvl, pend, mdm);
      check("R2-priority-sweep R2 R3 R4 R5 R6 R7 iir", iir, exp);
      check("R8 irq vs code", irq, ((exp & 15) != 1) ? 1 : 0);
      check("R13 ier readback", ier_q, ier_v);
    end

    // R9 and R10: set by empty pulse, acknowledged by read
    quiet();
    write_ier(4'h0); write_ier(4'h2);
    pulse_empty(); settle();
    check("R9 empty pulse sets", iir, 8'h02);
    read_iir(); settle();
    check("R10 read clears", iir, 8'h01);
    check("R10 irq low", irq, 0);

    // R10: read while line status shows leaves flag set
    write_ier(4'h6); pulse_empty();
    lsr_err = 4'h2; settle();
    check("R10 higher code shown", iir, 8'h06);
    read_iir();
    lsr_err = 4'h0; settle();
    check("R10 flag kept", iir, 8'h02);

    // R11: rise with holding empty sets flag
    write_ier(4'h0);
    lsr_thre = 1'b1;
    write_ier(4'h2); settle();
    check("R11 rise with empty", iir, 8'h02);
    read_iir(); settle();
    check("R11 acked", iir, 8'h01);
    write_ier(4'hA); settle();
    check("R11 no rise no set", iir, 8'h01);
    write_ier(4'h0); lsr_thre = 1'b0;
    write_ier(4'h2); settle();
    check("R11 rise without empty", iir, 8'h01);

    // R12: clearing bit 1 drops a pending flag that stays gone
    pulse_empty(); settle();
    check("R12 armed", iir, 8'h02);
    write_ier(4'h0);
    write_ier(4'h2); settle();
    check("R12 cleared by write", iir, 8'h01);

    // R4 boundary with FIFO on
    write_ier(4'h1); fifo_en = 1'b1; lsr_dr = 1'b1;
    rx_trig = 5'd14; rx_count = 5'd13; settle();
    check("R4 below trigger", iir, 8'hC1);
    rx_count = 5'd14; settle();
    check("R4 at trigger", iir, 8'hC4);
    char_timeout = 1'b1; settle();
    check("R3 timeout over data", iir, 8'hCC);
    write_ier(4'h0); settle();
    check("R3 masked by receive enable", iir, 8'hC1);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule